// File: doc/BRIEF.md
# Functional-Unit Reservation Bank with Register Wake-Up

This block holds the instructions waiting for one functional unit. Each slot keeps an opcode, an age (sequence number) and two source operands. An operand either already holds its value or waits on a physical register tag. Each physical register has its own wake-up line that runs to every slot. A pulse on that line means the register's result will show up on one of the result-bus lanes in the next cycle. Lanes are handed out dynamically, so a waiting operand compares its tag against every lane.

After a wake-up, an operand looks for its value on the lanes. If the rest of the slot is ready and the unit is free in that cycle, the slot issues at once with the lane value passed straight through. Otherwise the operand latches the value and the slot issues later. Each bank picks among ready slots by its own policy, fixed when the bank is built: round-robin for arithmetic units, or oldest-first for units that need program order. A flush input removes every slot younger than a given sequence number.

Top module: `rs_bank`

## Requirements
- R1: After reset no slot is occupied: `iss_valid` is 0 and `bank_full` is 0.
- R2: An accepted insert goes into the lowest-numbered empty slot and can issue from the next cycle on. A slot issues only when both operands are available. The issue outputs carry that slot's opcode, sequence number and operand values. The slot is emptied at the same clock edge and never issues twice.
- R3: A waiting operand takes a lane value only if its own tag's wake-up line pulsed in an earlier cycle. A pulse on another tag's line, or a lane carrying its tag with no prior pulse, leaves the operand waiting.
- R4: In the cycle a woken operand's tag appears on any lane (lane `k` uses `bus_tag[k*PRW +: PRW]` and `bus_data[k*XLEN +: XLEN]`), if the other operand is available and `fu_free` is 1, the slot issues in that same cycle with the lane value.
- R5: If the slot cannot issue in that cycle, the operand latches the lane value, and the slot later issues with the latched value.
- R6: An insert whose waiting operand's tag is pulsed on the wake-up vector in the insert cycle is treated as woken, so the value arriving on the next cycle is not lost.
- R7: With the round-robin policy, the search starts at the slot after the last one that issued (slot 0 first after reset) and wraps around.
- R8: With the oldest-first policy, the ready slot with the oldest sequence number issues. Sequence numbers are compared modulo 2^SEQW, and in-flight entries are assumed to span less than half that range.
- R9: When `flush` is 1, every slot whose sequence number is strictly younger than `flush_seq` is emptied at that edge and cannot issue in that cycle. An insert in the same cycle that is younger than `flush_seq` is dropped. Entries equal to `flush_seq` are kept.
- R10: `bank_full` is 1 when every slot is occupied, and an insert while it is 1 is ignored.
- R11: At most one slot issues per cycle, and `iss_valid` is 1 only while `fu_free` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_op | input | OPW | Opcode of the inserted instruction |
| ins_seq | input | SEQW | Sequence number (age) of the inserted instruction |
| ins_a_rdy | input | 1 | Source A already holds its value |
| ins_a_tag | input | PRW | Source A physical register tag |
| ins_a_val | input | XLEN | Source A value when ready |
| ins_b_rdy | input | 1 | Source B already holds its value |
| ins_b_tag | input | PRW | Source B physical register tag |
| ins_b_val | input | XLEN | Source B value when ready |
| wake_vec | input | PREGS | One line per physical register; its value arrives next cycle |
| bus_valid | input | NBUS | Lane carries a result |
| bus_tag | input | NBUS*PRW | Tag carried by each lane |
| bus_data | input | NBUS*XLEN | Value carried by each lane |
| fu_free | input | 1 | Functional unit accepts an instruction this cycle |
| flush | input | 1 | Remove entries younger than flush_seq |
| flush_seq | input | SEQW | Flush boundary sequence number |
| bank_full | output | 1 | All slots occupied |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_op | output | OPW | Issued opcode |
| iss_seq | output | SEQW | Issued sequence number |
| iss_a | output | XLEN | Issued source A value |
| iss_b | output | XLEN | Issued source B value |

## Verification
Two pairs of events can fall in the same cycle. One pair is an insert and a wake-up pulse for the tag it waits on. The other is a flush and an insert younger than the flush boundary. The bench raises the insert together with the pulse, then places the value on a lane in the next cycle and expects an issue carrying that value right away. It also raises a flush together with a younger insert and expects, once the unit frees up, only the surviving older entry to issue.

// File: rtl/rs_pkg.sv
package rs_pkg;

  typedef enum logic {
    SEL_ROUND_ROBIN = 1'b0,
    SEL_OLDEST      = 1'b1
  } sel_policy_e;

  // True when sequence number a is older than b, modulo 2^w.
  function automatic logic seq_before(logic [31:0] a, logic [31:0] b,
                                      int unsigned w);
    logic [31:0] d;
    d = a - b;
    return d[w-1];
  endfunction

endpackage

// File: rtl/rs_src.sv
module rs_src #(
  parameter int PREGS = 32,
  parameter int PRW   = 5,
  parameter int XLEN  = 16,
  parameter int NBUS  = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic                 ld_rdy,
  input  logic [PRW-1:0]       ld_tag,
  input  logic [XLEN-1:0]      ld_val,
  input  logic [PREGS-1:0]     wake_vec,
  input  logic [NBUS-1:0]      bus_valid,
  input  logic [NBUS*PRW-1:0]  bus_tag,
  input  logic [NBUS*XLEN-1:0] bus_data,
  output logic                 avail,
  output logic [XLEN-1:0]      cur_val
);

  logic            rdy_q, pend_q;
  logic [PRW-1:0]  tag_q;
  logic [XLEN-1:0] val_q;

  logic            bus_hit;
  logic [XLEN-1:0] bus_val;
  logic            wake_hit, ld_wake;
  logic            capture_ev, arm_ev;

  always_comb begin
    bus_hit = 1'b0;
    bus_val = '0;
    for (int b = 0; b < NBUS; b++) begin
      if (bus_valid[b] && bus_tag[b*PRW +: PRW] == tag_q) begin
        bus_hit = 1'b1;
        bus_val = bus_data[b*XLEN +: XLEN];
      end
    end
  end

  assign wake_hit   = wake_vec[tag_q];
  assign ld_wake    = wake_vec[ld_tag];
  assign capture_ev = !load && !rdy_q && pend_q && bus_hit;
  assign arm_ev     = !load && !rdy_q && !pend_q && wake_hit;

  assign avail   = rdy_q || (pend_q && bus_hit);
  assign cur_val = rdy_q ? val_q : bus_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      pend_q <= 1'b0;
      tag_q  <= '0;
      val_q  <= '0;
    end else if (load) begin
      rdy_q  <= ld_rdy;
      pend_q <= !ld_rdy && ld_wake;
      tag_q  <= ld_tag;
      val_q  <= ld_val;
    end else if (capture_ev) begin
      rdy_q  <= 1'b1;
      pend_q <= 1'b0;
      val_q  <= bus_val;
    end else if (arm_ev) begin
      pend_q <= 1'b1;
    end
  end

  // R5
  capture_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture_ev |=> (rdy_q && val_q == $past(bus_val)));

  // R6
  arm_on_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !ld_rdy && ld_wake) |=> pend_q);

  // R3
  no_early_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !rdy_q && !pend_q) |=> !rdy_q);

endmodule

// File: rtl/rs_entry.sv
module rs_entry #(
  parameter int PREGS = 32,
  parameter int PRW   = 5,
  parameter int XLEN  = 16,
  parameter int NBUS  = 2,
  parameter int OPW   = 4,
  parameter int SEQW  = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load,
  input  logic [OPW-1:0]       ld_op,
  input  logic [SEQW-1:0]      ld_seq,
  input  logic                 ld_a_rdy,
  input  logic [PRW-1:0]       ld_a_tag,
  input  logic [XLEN-1:0]      ld_a_val,
  input  logic                 ld_b_rdy,
  input  logic [PRW-1:0]       ld_b_tag,
  input  logic [XLEN-1:0]      ld_b_val,
  input  logic [PREGS-1:0]     wake_vec,
  input  logic [NBUS-1:0]      bus_valid,
  input  logic [NBUS*PRW-1:0]  bus_tag,
  input  logic [NBUS*XLEN-1:0] bus_data,
  input  logic                 flush,
  input  logic [SEQW-1:0]      flush_seq,
  input  logic                 take,
  output logic                 valid,
  output logic                 req,
  output logic [OPW-1:0]       op,
  output logic [SEQW-1:0]      seq,
  output logic [XLEN-1:0]      a_val,
  output logic [XLEN-1:0]      b_val
);

  logic valid_q;
  logic [OPW-1:0]  op_q;
  logic [SEQW-1:0] seq_q;
  logic a_av, b_av;
  logic kill_ev;

  rs_src #(.PREGS(PREGS), .PRW(PRW), .XLEN(XLEN), .NBUS(NBUS)) u_src_a (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ld_rdy(ld_a_rdy), .ld_tag(ld_a_tag), .ld_val(ld_a_val),
    .wake_vec(wake_vec), .bus_valid(bus_valid), .bus_tag(bus_tag),
    .bus_data(bus_data), .avail(a_av), .cur_val(a_val)
  );

  rs_src #(.PREGS(PREGS), .PRW(PRW), .XLEN(XLEN), .NBUS(NBUS)) u_src_b (
    .clk(clk), .rst_n(rst_n), .load(load),
    .ld_rdy(ld_b_rdy), .ld_tag(ld_b_tag), .ld_val(ld_b_val),
    .wake_vec(wake_vec), .bus_valid(bus_valid), .bus_tag(bus_tag),
    .bus_data(bus_data), .avail(b_av), .cur_val(b_val)
  );

  assign kill_ev = flush && valid_q &&
                   rs_pkg::seq_before(32'(flush_seq), 32'(seq_q), SEQW);

  assign valid = valid_q;
  assign req   = valid_q && a_av && b_av && !kill_ev;
  assign op    = op_q;
  assign seq   = seq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      op_q    <= '0;
      seq_q   <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      op_q    <= ld_op;
      seq_q   <= ld_seq;
    end else if (take || kill_ev) begin
      valid_q <= 1'b0;
    end
  end

  // R2
  load_into_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !valid_q);

  // R2
  take_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !valid_q);

  // R9
  flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kill_ev && !load) |=> !valid_q);

endmodule

// File: rtl/rs_alloc.sv
module rs_alloc #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] free,
  output logic [N-1:0] pick,
  output logic         any
);

  function automatic logic [N-1:0] lowest_set(logic [N-1:0] v);
    logic [N-1:0] r;
    logic done;
    r = '0;
    done = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (v[i] && !done) begin
        r[i] = 1'b1;
        done = 1'b1;
      end
    end
    return r;
  endfunction

  assign pick = lowest_set(free);
  assign any  = |free;

  // R2
  pick_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pick) && ((pick & ~free) == '0));

endmodule

// File: rtl/rs_select.sv
module rs_select #(
  parameter int N    = 8,
  parameter int SEQW = 6,
  parameter rs_pkg::sel_policy_e POLICY = rs_pkg::SEL_ROUND_ROBIN
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic [N*SEQW-1:0] seq_flat,
  input  logic          fire,
  output logic [N-1:0]  gnt,
  output logic          any
);

  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] ptr_q;
  logic [N-1:0]  gnt_rr, gnt_age;
  logic [IW-1:0] gnt_idx;

  // Round-robin: first request after the last issued slot.
  always_comb begin
    logic found;
    found  = 1'b0;
    gnt_rr = '0;
    for (int k = 1; k <= N; k++) begin
      int j;
      j = (int'(ptr_q) + k) % N;
      if (req[j] && !found) begin
        gnt_rr[j] = 1'b1;
        found     = 1'b1;
      end
    end
  end

  // Oldest-first: smallest sequence number, wrap-aware.
  always_comb begin
    logic found;
    int   best;
    found   = 1'b0;
    best    = 0;
    gnt_age = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!found ||
          rs_pkg::seq_before(32'(seq_flat[i*SEQW +: SEQW]),
                             32'(seq_flat[best*SEQW +: SEQW]), SEQW))) begin
        best  = i;
        found = 1'b1;
      end
    end
    gnt_age[best] = found;
  end

  assign gnt = (POLICY == rs_pkg::SEL_OLDEST) ? gnt_age : gnt_rr;
  assign any = |req;

  always_comb begin
    gnt_idx = '0;
    for (int i = 0; i < N; i++)
      if (gnt[i]) gnt_idx = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    ptr_q <= IW'(N - 1);
    else if (fire) ptr_q <= gnt_idx;
  end

  // R11
  gnt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));

  // R11
  gnt_when_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));

endmodule

// File: rtl/rs_bank.sv
module rs_bank #(
  parameter int ENTRIES = 8,
  parameter int PREGS   = 32,
  parameter int XLEN    = 16,
  parameter int NBUS    = 2,
  parameter int OPW     = 4,
  parameter int SEQW    = 6,
  parameter rs_pkg::sel_policy_e POLICY = rs_pkg::SEL_ROUND_ROBIN,
  localparam int PRW    = $clog2(PREGS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_valid,
  input  logic [OPW-1:0]       ins_op,
  input  logic [SEQW-1:0]      ins_seq,
  input  logic                 ins_a_rdy,
  input  logic [PRW-1:0]       ins_a_tag,
  input  logic [XLEN-1:0]      ins_a_val,
  input  logic                 ins_b_rdy,
  input  logic [PRW-1:0]       ins_b_tag,
  input  logic [XLEN-1:0]      ins_b_val,
  input  logic [PREGS-1:0]     wake_vec,
  input  logic [NBUS-1:0]      bus_valid,
  input  logic [NBUS*PRW-1:0]  bus_tag,
  input  logic [NBUS*XLEN-1:0] bus_data,
  input  logic                 fu_free,
  input  logic                 flush,
  input  logic [SEQW-1:0]      flush_seq,
  output logic                 bank_full,
  output logic                 iss_valid,
  output logic [OPW-1:0]       iss_op,
  output logic [SEQW-1:0]      iss_seq,
  output logic [XLEN-1:0]      iss_a,
  output logic [XLEN-1:0]      iss_b
);

  logic [ENTRIES-1:0]      valid, req, pick, gnt, take, load;
  logic [ENTRIES*SEQW-1:0] seq_flat;
  logic [OPW-1:0]          op_arr [ENTRIES];
  logic [XLEN-1:0]         a_arr  [ENTRIES];
  logic [XLEN-1:0]         b_arr  [ENTRIES];
  logic                    free_any, req_any, fire;
  logic                    ins_dropped;

  assign ins_dropped = flush &&
                       rs_pkg::seq_before(32'(flush_seq), 32'(ins_seq), SEQW);

  rs_alloc #(.N(ENTRIES)) u_alloc (
    .clk(clk), .rst_n(rst_n), .free(~valid), .pick(pick), .any(free_any)
  );

  assign load = (ins_valid && free_any && !ins_dropped) ? pick : '0;
  assign take = fu_free ? gnt : '0;
  assign fire = |take;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    rs_entry #(
      .PREGS(PREGS), .PRW(PRW), .XLEN(XLEN), .NBUS(NBUS),
      .OPW(OPW), .SEQW(SEQW)
    ) u_ent (
      .clk(clk), .rst_n(rst_n), .load(load[g]),
      .ld_op(ins_op), .ld_seq(ins_seq),
      .ld_a_rdy(ins_a_rdy), .ld_a_tag(ins_a_tag), .ld_a_val(ins_a_val),
      .ld_b_rdy(ins_b_rdy), .ld_b_tag(ins_b_tag), .ld_b_val(ins_b_val),
      .wake_vec(wake_vec), .bus_valid(bus_valid), .bus_tag(bus_tag),
      .bus_data(bus_data), .flush(flush), .flush_seq(flush_seq),
      .take(take[g]), .valid(valid[g]), .req(req[g]),
      .op(op_arr[g]), .seq(seq_flat[g*SEQW +: SEQW]),
      .a_val(a_arr[g]), .b_val(b_arr[g])
    );
  end

  rs_select #(.N(ENTRIES), .SEQW(SEQW), .POLICY(POLICY)) u_sel (
    .clk(clk), .rst_n(rst_n), .req(req), .seq_flat(seq_flat),
    .fire(fire), .gnt(gnt), .any(req_any)
  );

  always_comb begin
    iss_op  = '0;
    iss_seq = '0;
    iss_a   = '0;
    iss_b   = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (gnt[i]) begin
        iss_op  = op_arr[i];
        iss_seq = seq_flat[i*SEQW +: SEQW];
        iss_a   = a_arr[i];
        iss_b   = b_arr[i];
      end
    end
  end

  assign iss_valid = fu_free && req_any;
  assign bank_full = &valid;

  // R11
  issue_needs_unit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    iss_valid |-> fu_free);

  // R10
  full_blocks_insert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_full |-> (load == '0));

  // R1
  reset_empty_chk: assert property (@(posedge clk)
    $rose(rst_n) |-> (valid == '0));

endmodule

// File: tb/rs_bank_bench.sv
module rs_bank_bench;
  localparam int E = 8, PREGS = 32, PRW = 5, XLEN = 16, NBUS = 2, OPW = 4, SEQW = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid, ins_a_rdy, ins_b_rdy, fu_free, flush;
  logic [OPW-1:0] ins_op;
  logic [SEQW-1:0] ins_seq, flush_seq;
  logic [PRW-1:0] ins_a_tag, ins_b_tag;
  logic [XLEN-1:0] ins_a_val, ins_b_val;
  logic [PREGS-1:0] wake_vec;
  logic [NBUS-1:0] bus_valid;
  logic [NBUS*PRW-1:0] bus_tag;
  logic [NBUS*XLEN-1:0] bus_data;

  logic full_r, full_o, iv_r, iv_o;
  logic [OPW-1:0] op_r, op_o;
  logic [SEQW-1:0] sq_r, sq_o;
  logic [XLEN-1:0] a_r, a_o, b_r, b_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  rs_bank u_rs_bank (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op), .ins_seq(ins_seq),
    .ins_a_rdy(ins_a_rdy), .ins_a_tag(ins_a_tag), .ins_a_val(ins_a_val),
    .ins_b_rdy(ins_b_rdy), .ins_b_tag(ins_b_tag), .ins_b_val(ins_b_val),
    .wake_vec(wake_vec), .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .fu_free(fu_free), .flush(flush), .flush_seq(flush_seq), .bank_full(full_r),
    .iss_valid(iv_r), .iss_op(op_r), .iss_seq(sq_r), .iss_a(a_r), .iss_b(b_r));

  rs_bank #(.POLICY(rs_pkg::SEL_OLDEST)) u_rs_bank_age (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op), .ins_seq(ins_seq),
    .ins_a_rdy(ins_a_rdy), .ins_a_tag(ins_a_tag), .ins_a_val(ins_a_val),
    .ins_b_rdy(ins_b_rdy), .ins_b_tag(ins_b_tag), .ins_b_val(ins_b_val),
    .wake_vec(wake_vec), .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
    .fu_free(fu_free), .flush(flush), .flush_seq(flush_seq), .bank_full(full_o),
    .iss_valid(iv_o), .iss_op(op_o), .iss_seq(sq_o), .iss_a(a_o), .iss_b(b_o));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Issue state of both banks: v=0 means no issue expected.
  task automatic chk_iss(string req, bit v_rr, int s_rr, bit v_age, int s_age);
    chk({req, " rr valid"}, 32'(iv_r), 32'(v_rr));
    if (v_rr) chk({req, " rr seq"}, 32'(sq_r), 32'(s_rr));
    chk({req, " age valid"}, 32'(iv_o), 32'(v_age));
    if (v_age) chk({req, " age seq"}, 32'(sq_o), 32'(s_age));
  endtask

  task automatic idle();
    ins_valid = 0; ins_op = '0; ins_seq = '0;
    ins_a_rdy = 0; ins_a_tag = '0; ins_a_val = '0;
    ins_b_rdy = 0; ins_b_tag = '0; ins_b_val = '0;
    wake_vec = '0; bus_valid = '0; bus_tag = '0; bus_data = '0;
    flush = 0; flush_seq = '0;
  endtask

  // Step to the next cycle: inputs return to idle, fu_free kept.
  task automatic nxt();
    @(negedge clk);
    idle();
  endtask

  task automatic ins(int seq, int op, bit ar, int at, int av, bit br, int bt, int bv);
    ins_valid = 1; ins_seq = SEQW'(seq); ins_op = OPW'(op);
    ins_a_rdy = ar; ins_a_tag = PRW'(at); ins_a_val = XLEN'(av);
    ins_b_rdy = br; ins_b_tag = PRW'(bt); ins_b_val = XLEN'(bv);
  endtask

  task automatic lane(int k, int tag, int data);
    bus_valid[k] = 1'b1;
    bus_tag[k*PRW +: PRW] = PRW'(tag);
    bus_data[k*XLEN +: XLEN] = XLEN'(data);
  endtask

  task automatic t_reset();
    #1;
    chk("R1 iss_valid", 32'(iv_r | iv_o), 0);
    chk("R1 bank_full", 32'(full_r | full_o), 0);
  endtask

  task automatic t_basic();
    nxt(); ins(1, 3, 1, 0, 'h0aa, 1, 0, 'h0bb); #1;
    chk_iss("R2 not before next cycle", 0, 0, 0, 0);
    nxt(); #1;
    chk_iss("R2 issue", 1, 1, 1, 1);
    chk("R2 op", 32'(op_r), 3);
    chk("R2 a", 32'(a_r), 'h0aa);
    chk("R2 b", 32'(b_r), 'h0bb);
    nxt(); #1;
    chk_iss("R2 slot freed", 0, 0, 0, 0);
  endtask

  task automatic t_direct();
    nxt(); ins(2, 5, 0, 5, 0, 1, 0, 'h22); #1;
    nxt(); #1; chk_iss("R3 waiting", 0, 0, 0, 0);
    nxt(); wake_vec[5] = 1'b1; #1; chk_iss("R4 wake cycle", 0, 0, 0, 0);
    nxt(); lane(1, 5, 'h1234); #1;
    chk_iss("R4 direct issue", 1, 2, 1, 2);
    chk("R4 bypass a", 32'(a_r), 'h1234);
    chk("R4 b", 32'(b_r), 'h22);
    nxt(); #1; chk_iss("R4 freed", 0, 0, 0, 0);
  endtask

  task automatic t_capture();
    nxt(); ins(3, 1, 1, 0, 'h11, 0, 6, 0); #1;
    nxt(); wake_vec[6] = 1'b1; #1;
    nxt(); fu_free = 0; lane(0, 6, 'h0606); #1;
    chk_iss("R5 busy unit", 0, 0, 0, 0);
    nxt(); fu_free = 1; #1;
    chk_iss("R5 issue later", 1, 3, 1, 3);
    chk("R5 captured b", 32'(b_r), 'h0606);
    chk("R5 captured b age", 32'(b_o), 'h0606);
    nxt(); #1; chk_iss("R5 freed", 0, 0, 0, 0);
  endtask

  task automatic t_insert_wake();
    nxt(); ins(4, 2, 0, 7, 0, 1, 0, 'h44); wake_vec[7] = 1'b1; #1;
    nxt(); lane(0, 7, 'h0777); #1;
    chk_iss("R6 same-cycle wake", 1, 4, 1, 4);
    chk("R6 value", 32'(a_r), 'h0777);
    nxt(); #1; chk_iss("R6 freed", 0, 0, 0, 0);
  endtask

  task automatic t_ignore();
    nxt(); ins(5, 2, 0, 9, 0, 1, 0, 'h55); #1;
    nxt(); wake_vec[10] = 1'b1; #1;
    nxt(); lane(0, 10, 'h1010); #1; chk_iss("R3 other tag ignored", 0, 0, 0, 0);
    nxt(); lane(1, 9, 'hdead); #1; chk_iss("R3 lane without wake", 0, 0, 0, 0);
    nxt(); wake_vec[9] = 1'b1; #1;
    nxt(); lane(1, 9, 'h0999); #1;
    chk_iss("R3 proper wake", 1, 5, 1, 5);
    chk("R3 value", 32'(a_r), 'h0999);
    nxt(); #1; chk_iss("R3 freed", 0, 0, 0, 0);
  endtask

  task automatic t_order(int s0, int s1, int s2, string tag);
    fu_free = 0;
    nxt(); ins(s0, 1, 1, 0, 1, 1, 0, 1);
    nxt(); ins(s1, 1, 1, 0, 1, 1, 0, 1);
    nxt(); ins(s2, 1, 1, 0, 1, 1, 0, 1);
    nxt(); fu_free = 1; #1;
    // Slots 0,1,2 hold s0,s1,s2; round-robin pointer sits on slot 0.
    if (tag == "wrap") begin
      chk_iss("R7 R8 wrap first", 1, s1, 1, s2);
      nxt(); #1; chk_iss("R7 R8 wrap second", 1, s2, 1, s1);
      nxt(); #1; chk_iss("R7 R8 wrap third", 1, s0, 1, s0);
    end else begin
      chk_iss("R7 R8 first", 1, s1, 1, s0);
      nxt(); #1; chk_iss("R7 R8 second", 1, s2, 1, s1);
      nxt(); #1; chk_iss("R7 R8 third", 1, s0, 1, s2);
    end
    nxt(); #1; chk_iss("R7 drained", 0, 0, 0, 0);
  endtask

  task automatic t_flush();
    fu_free = 0;
    nxt(); ins(20, 1, 1, 0, 1, 1, 0, 1);
    nxt(); ins(21, 1, 1, 0, 1, 1, 0, 1);
    nxt(); ins(22, 1, 1, 0, 1, 1, 0, 1);
    nxt(); flush = 1; flush_seq = 20; ins(23, 1, 1, 0, 1, 1, 0, 1); #1;
    chk_iss("R9 flush cycle", 0, 0, 0, 0);
    nxt(); fu_free = 1; #1;
    chk_iss("R9 boundary kept", 1, 20, 1, 20);
    nxt(); #1; chk_iss("R9 younger removed", 0, 0, 0, 0);
  endtask

  task automatic t_full();
    fu_free = 0;
    for (int i = 0; i < E; i++) begin
      nxt(); ins(40 + i, 1, 1, 0, 1, 1, 0, 1); #1;
      chk("R10 not yet full", 32'(full_r), 0);
    end
    nxt(); ins(48, 1, 1, 0, 1, 1, 0, 1); #1;
    chk("R10 full", 32'(full_r & full_o), 1);
    for (int i = 0; i < E; i++) begin
      nxt(); fu_free = 1; #1;
      chk_iss("R10 R8 drain", 1, (i < E - 1) ? 41 + i : 40, 1, 40 + i);
      if (i == 1) chk("R2 slot reusable", 32'(full_r), 0);
    end
    nxt(); #1; chk_iss("R10 overflow insert ignored", 0, 0, 0, 0);
  endtask

  initial begin
    idle(); fu_free = 1;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk); rst_n = 1;
    t_reset();
    t_basic();
    t_direct();
    t_capture();
    t_insert_wake();
    t_ignore();
    t_order(10, 11, 12, "plain");
    t_order(0, 63, 62, "wrap");
    t_flush();
    t_full();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule